// File: doc/BRIEF.md
# Serial DAC Command Shift Interface

This block is the three-wire serial front end of a voltage-output DAC controller. It samples an active-low chip select, a serial clock and a serial data line. All three are brought into the system clock domain through synchronisers, and their edges are detected there. While chip select is low, each rising edge of the serial clock shifts one data bit into a 16-bit shift register, most significant bit first. When chip select returns high after a whole number of 16-bit groups, the last 16 bits received are presented to the command decoder, together with a valid pulse one system clock wide.

The register's oldest bit is driven on a serial data output, so devices can be chained or the written word read back. A mode input selects the output timing. In rising mode the output changes on the serial clock rising edge and trails the input by exactly 16 clocks. In falling mode it changes on the falling edge and trails the input by 16.5 clocks. A shutdown input freezes the serial output level. Shifting and word delivery continue during shutdown. The system clock must run at least four times faster than the serial clock.

Top module: `dsf_serial_front`

## Requirements
- R1: After reset, word_o is 0, word_valid_o is 0 and dout_o is 0.
- R2: A frame of 16 serial clocks delivers the bits in arrival order: the first bit lands in word_o[15] and the sixteenth in word_o[0].
- R3: Serial clock edges and data while cs_n_i is high change neither the shift register nor dout_o.
- R4: A frame sent as two 8-bit bursts, with the serial clock idle between them and cs_n_i kept low, is delivered as one word.
- R5: A word is delivered only after cs_n_i rises. word_valid_o is then high for exactly one system clock, and word_o is held until the next delivery.
- R6: If cs_n_i rises after a clock count that is not a nonzero multiple of 16, word_valid_o stays low and word_o keeps its previous value.
- R7: When more than 16 clocks arrive in one frame, with the count a multiple of 16, the last 16 bits received form the word.
- R8: With dout_mode_i = 0, dout_o changes on serial clock rising edges. After the rising edge of bit j, it carries bit j-16.
- R9: With dout_mode_i = 1, dout_o changes on serial clock falling edges. After the falling edge that follows bit j, it carries bit j-16, so it trails the input by 16.5 clocks.
- R10: While shutdown_i is 1, dout_o keeps its level, but bits are still shifted and words are still delivered.
- R11: A chip-select low period with no serial clock edges produces no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip select, active low (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| din_i | input | 1 | Serial data in, sampled on serial clock rising edges |
| dout_mode_i | input | 1 | 0: output changes on rising edges; 1: output changes on falling edges |
| shutdown_i | input | 1 | 1 freezes dout_o |
| word_o | output | 16 | Last delivered command word |
| word_valid_o | output | 1 | One-cycle delivery strobe |
| dout_o | output | 1 | Serial data out |

## Verification
Two functions can fall in the same system cycle: a new bit entering the shift register and the oldest bit leaving on the serial output. The bench provokes this on every serial clock edge. It checks the output twice per bit, once just before the falling edge and once just before the next rising edge. In each check the observed level is compared with a bench-side history of every bit sent, which tells the 16-clock mode from the 16.5-clock mode. Chip-select release is the other meeting point, where the bit count decides whether a word is delivered. The bench sweeps every frame length from 1 to 15 clocks and several longer lengths, and judges each frame by the number of strobe cycles and by the value held on the word output.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
  typedef enum logic {
    DOUT_ON_RISE = 1'b0,
    DOUT_ON_FALL = 1'b1
  } dout_mode_e;

  // bit positions inside the synchronised input vector
  localparam int unsigned IDX_DIN  = 0;
  localparam int unsigned IDX_SCLK = 1;
  localparam int unsigned IDX_CS   = 2;
  localparam int unsigned N_INPUTS = 3;
endpackage

// File: rtl/dsf_sync.sv
module dsf_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dsf_edge.sv
module dsf_edge #(
  parameter int unsigned W        = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/dsf_frame.sv
module dsf_frame #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low_i,
  input  logic              cs_rise_i,
  input  logic              cs_fall_i,
  input  logic              sclk_rise_i,
  input  logic              din_i,
  output logic              msb_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);
  localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_base;
  logic              seen_q, seen_d, seen_base;
  logic [WORD_W-1:0] word_q;
  logic              word_en;
  logic              valid_q, valid_d;
  logic              shift_en;

  assign shift_en = cs_low_i & sclk_rise_i;

  always_comb begin
    cnt_base  = cs_fall_i ? '0 : cnt_q;
    seen_base = cs_fall_i ? 1'b0 : seen_q;
    shreg_d   = shreg_q;
    cnt_d     = cnt_base;
    seen_d    = seen_base;
    valid_d   = 1'b0;
    word_en   = 1'b0;
    if (shift_en) begin
      shreg_d = {shreg_q[WORD_W-2:0], din_i};
      cnt_d   = (cnt_base == CNT_LAST) ? '0 : cnt_base + 1'b1;
      seen_d  = 1'b1;
    end
    if (cs_rise_i) begin
      valid_d = seen_q & (cnt_q == '0);
      word_en = valid_d;
      cnt_d   = '0;
      seen_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      if (shift_en) shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= shreg_q;
  end

  assign msb_o        = shreg_q[WORD_W-1];
  assign word_o       = word_q;
  assign word_valid_o = valid_q;

  a_r3_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low_i |=> $stable(shreg_q));
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  a_r5_strobe_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(cs_rise_i));
  a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(word_q));
  a_r6_partial_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && cnt_q != '0) |=> !valid_q);
  a_r2_word_from_register: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> (word_q == $past(shreg_q)));
endmodule

// File: rtl/dsf_dout.sv
module dsf_dout
  import dsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_low_i,
  input  logic       sclk_rise_i,
  input  logic       sclk_fall_i,
  input  logic       msb_i,
  input  dout_mode_e mode_i,
  input  logic       shutdown_i,
  output logic       dout_o
);
  logic spill_q;
  logic dout_q, dout_d, dout_en;
  logic spill_en;

  assign spill_en = cs_low_i & sclk_rise_i;

  always_comb begin
    dout_en = 1'b0;
    dout_d  = dout_q;
    if (!shutdown_i && cs_low_i) begin
      if (mode_i == DOUT_ON_RISE && sclk_rise_i) begin
        dout_en = 1'b1;
        dout_d  = msb_i;
      end else if (mode_i == DOUT_ON_FALL && sclk_fall_i) begin
        dout_en = 1'b1;
        dout_d  = spill_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        spill_q <= 1'b0;
    else if (spill_en) spill_q <= msb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= 1'b0;
    else if (dout_en) dout_q <= dout_d;
  end

  assign dout_o = dout_q;

  a_r10_frozen_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> $stable(dout_q));
  a_r8_rise_mode_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DOUT_ON_RISE && !sclk_rise_i) |=> $stable(dout_q));
  a_r9_fall_mode_timing: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == DOUT_ON_FALL && !sclk_fall_i) |=> $stable(dout_q));
endmodule

// File: rtl/dsf_serial_front.sv
module dsf_serial_front
  import dsf_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic              dout_mode_i,
  input  logic              shutdown_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              dout_o
);
  localparam logic [N_INPUTS-1:0] IN_RST = N_INPUTS'(1) << IDX_CS;

  logic [N_INPUTS-1:0] raw_in, sync_in;
  logic [1:0]          edge_lvl, edge_rise, edge_fall;
  logic                cs_low, msb;
  dout_mode_e          mode;

  assign raw_in[IDX_DIN]  = din_i;
  assign raw_in[IDX_SCLK] = sclk_i;
  assign raw_in[IDX_CS]   = cs_n_i;

  dsf_sync #(.W(N_INPUTS), .STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(raw_in), .sync_o(sync_in));

  // edge vector: [1] chip select, [0] serial clock
  assign edge_lvl = {sync_in[IDX_CS], sync_in[IDX_SCLK]};

  dsf_edge #(.W(2), .RST_VAL(2'b10)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(edge_lvl),
    .rise_o(edge_rise), .fall_o(edge_fall));

  assign cs_low = ~sync_in[IDX_CS];
  assign mode   = dout_mode_e'(dout_mode_i);

  dsf_frame #(.WORD_W(WORD_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_low_i(cs_low),
    .cs_rise_i(edge_rise[1]), .cs_fall_i(edge_fall[1]),
    .sclk_rise_i(edge_rise[0]), .din_i(sync_in[IDX_DIN]),
    .msb_o(msb), .word_o(word_o), .word_valid_o(word_valid_o));

  dsf_dout u_dout (
    .clk(clk), .rst_n(rst_n), .cs_low_i(cs_low),
    .sclk_rise_i(edge_rise[0]), .sclk_fall_i(edge_fall[0]),
    .msb_i(msb), .mode_i(mode), .shutdown_i(shutdown_i), .dout_o(dout_o));
endmodule

// File: tb/tb_dsf_serial_front.sv
module tb_dsf_serial_front;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, din, mode, sd;
  logic [15:0] word;
  logic word_valid, dout;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic [63:0] hist = '0;
  logic [15:0] last_word = '0;
  logic held = 1'b0;

  always #4 clk = ~clk;

  dsf_serial_front dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
    .dout_mode_i(mode), .shutdown_i(sd), .word_o(word),
    .word_valid_o(word_valid), .dout_o(dout));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clk_bit(input logic b, input bit check, input string req);
    logic e;
    din = b;
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    hist = {hist[62:0], b};
    repeat (H) @(negedge clk);
    if (check) begin
      e = sd ? held : (mode ? hist[17] : hist[16]);
      chk(dout === e, req, {31'd0, dout}, {31'd0, e});
    end
    sclk = 1'b0;
    repeat (H) @(negedge clk);
    if (check) begin
      e = sd ? held : hist[16];
      chk(dout === e, req, {31'd0, dout}, {31'd0, e});
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n, input int split,
                       input bit check, input string req);
    int pulses;
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      if (split != 0 && i == n - 1 - split) repeat (3 * H) @(negedge clk);
      clk_bit(v[i], check, req);
    end
    cs_n = 1'b1;
    pulses = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (word_valid === 1'b1) pulses++;
    end
    if (n > 0 && n % 16 == 0) begin
      chk(pulses == 1, "R5", pulses, 1);
      chk(word === v[15:0], req, {16'd0, word}, {16'd0, v[15:0]});
      last_word = v[15:0];
    end else begin
      chk(pulses == 0, "R6", pulses, 0);
      chk(word === last_word, "R6", {16'd0, word}, {16'd0, last_word});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; mode = 1'b0; sd = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(word === 16'h0, "R1", {16'd0, word}, 0);
    chk(word_valid === 1'b0, "R1", {31'd0, word_valid}, 0);
    chk(dout === 1'b0, "R1", {31'd0, dout}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 empty chip-select window
    frame(32'h0, 0, 0, 1, "R11");

    // R2 / R8 sweep in rising mode
    frame(32'h0000FFFF, 16, 0, 1, "R2");
    frame(32'h00000000, 16, 0, 1, "R2");
    frame(32'h00008001, 16, 0, 1, "R2");
    for (int i = 0; i < 24; i++) begin
      w = 16'((i * 40503 + 12345) ^ (i << 7));
      frame({16'd0, w}, 16, 0, 1, "R8");
    end

    // R9 falling mode
    mode = 1'b1;
    for (int i = 0; i < 16; i++) begin
      w = 16'((i * 25173 + 13849) ^ (i << 3));
      frame({16'd0, w}, 16, 0, 1, "R9");
    end
    mode = 1'b0;

    // R4 two 8-bit bursts
    for (int i = 0; i < 8; i++) begin
      w = 16'(i * 7919 + 4242);
      frame({16'd0, w}, 16, 8, 1, "R4");
    end

    // R6 partial frames
    for (int n = 1; n < 16; n++) frame(32'h5A3C_96E1 ^ n, n, 0, 1, "R6");
    frame(32'h1357_9BDF, 17, 0, 1, "R6");
    frame(32'h2468_ACE0, 24, 0, 1, "R6");
    frame(32'h7FFF_0001, 31, 0, 1, "R6");

    // R7 long frames, last 16 bits kept
    frame(32'hDEAD_BEEF, 32, 0, 1, "R7");
    frame(32'h0F0F_A5C3, 32, 0, 1, "R7");
    mode = 1'b1;
    frame(32'hCAFE_1234, 32, 0, 1, "R7");
    mode = 1'b0;

    // R3 activity with chip select high is ignored
    for (int i = 0; i < 20; i++) begin
      din = i[0] ^ i[2];
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    chk(dout === hist[16], "R3", {31'd0, dout}, {31'd0, hist[16]});
    chk(word_valid === 1'b0, "R3", {31'd0, word_valid}, 0);
    frame(32'h0000_6B2D, 16, 0, 1, "R3");

    // R10 shutdown freezes output, words still delivered
    held = hist[16];
    sd = 1'b1;
    frame(32'h0000_F00F, 16, 0, 1, "R10");
    frame(32'h0000_0FF0, 16, 0, 1, "R10");
    sd = 1'b0;
    frame(32'h0000_3C3C, 16, 0, 1, "R10");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule